// File: doc/BRIEF.md
# Forty-Bit Shift, Rotate and Bit-Field Unit

This block is the shift stage of a signal-processing datapath. It has a 40-bit operand width, so that accumulator values as well as sign-extended or zero-extended 32-bit register values pass through it unchanged. In one cycle it can do any one of the following:
- an arithmetic or logical shift by a signed amount;
- a rotate through a one-bit carry;
- a count of the redundant sign bits, used as the shift amount that normalizes the operand;
- extraction of a bit field into the low end of the result, with zero or sign fill;
- deposit of a low-order field into a target word at a chosen position.

The result path is combinational. The one piece of state is the rotate carry. It updates on the clock edge only when a valid rotate is issued. Flags for zero and negative come from the 40-bit result. The surrounding datapath supplies the operand, the field source, the opcode and the controls. Register access and instruction decoding stay outside the block.

Top module: `xsh_unit`

## Requirements
- R1: Opcode 0 (arithmetic shift): a positive amount shifts the operand left and fills with zeros. A negative amount shifts it right and fills with copies of bit 39. The amount is two's complement on `shift_amt`.
- R2: Opcode 1 (logical shift): left shifts behave as in R1. A negative amount shifts right and fills with zeros.
- R3: A shift or rotate amount whose magnitude is above 40 acts as magnitude 40. An arithmetic shift left by 40 or more gives zero. An arithmetic right shift by 40 or more gives 40 copies of bit 39.
- R4: Opcode 2 (rotate) treats {carry, operand} as a 41-bit ring, with the carry above bit 39. A positive amount rotates toward the carry and a negative amount rotates away from it. The result is the low 40 bits of the ring and the new carry is its top bit. An amount of zero returns the operand unchanged.
- R5: The carry register clears on reset. It loads the new carry only on a clock edge with `op_valid` high and opcode 2. Otherwise it keeps its value.
- R6: Opcode 3 (sign detect) returns, zero-extended, the number of bits directly below bit 39 that equal bit 39, before the first bit that differs. The value lies in 0 to 39, and both an all-zero and an all-one operand give 39.
- R7: Opcode 4 (extract) returns operand bits [pos+len-1:pos] at result bits [len-1:0]. When `fld_sext` is 0 the upper bits are zero. When it is 1 they copy the field's top bit.
- R8: In an extract, field bits above bit 39 read as zero. A length of 0 gives zero, a length of 40 or more takes the whole remaining operand, and a position of 40 or more gives zero.
- R9: Opcode 5 (deposit) replaces operand bits [pos+len-1:pos] with `field_src` bits [len-1:0] and leaves every other operand bit unchanged. Field bits that would land above bit 39 are dropped.
- R10: `flag_zero` is 1 exactly when the 40-bit result is zero. `flag_neg` equals result bit 39.
- R11: Opcodes 6 and 7 pass the operand through to the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the carry register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Qualifies the operation; only a valid rotate updates the carry |
| op_code | input | 3 | Operation select |
| operand | input | 40 | Operand, shift source or deposit target |
| field_src | input | 40 | Source of the deposited field (low bits) |
| shift_amt | input | 7 | Signed shift or rotate amount |
| fld_pos | input | 6 | Bit position of the field's lowest bit |
| fld_len | input | 6 | Field length in bits |
| fld_sext | input | 1 | Extract fill: 0 zero, 1 sign |
| result | output | 40 | Operation result |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result bit 39 |
| carry_q | output | 1 | Rotate carry register |

## Verification
The bench goes after the amount edges: 0, ±1, ±39, ±40 and values past 40 up to -64. A design that failed to saturate there would wrap the amount and return a partly shifted word instead of zero or all sign bits. Rotates are chained so that each carry feeds the next one, and they are mixed with invalid rotates and other opcodes. A carry that loaded on the wrong cycle, or rotated 40 bits instead of 41, would make later results disagree. Sign detect is driven with all-zero, all-one and single-transition operands, where an off-by-one count shows at once. Extract and deposit are run with a zero length, full length, a position at or past 40, and fields that straddle bit 39, where a wrong mask leaks or drops bits.

// File: rtl/xsh_pkg.sv
package xsh_pkg;

   typedef enum logic [2:0] {
      OP_ASH  = 3'd0,
      OP_LSH  = 3'd1,
      OP_ROT  = 3'd2,
      OP_SGN  = 3'd3,
      OP_EXT  = 3'd4,
      OP_DEP  = 3'd5,
      OP_PS6  = 3'd6,
      OP_PS7  = 3'd7
   } xsh_op_e;

   localparam int unsigned XSH_DATA_W = 40;
   localparam int unsigned XSH_AMT_W  = 7;
   localparam int unsigned XSH_POS_W  = 6;

endpackage

// File: rtl/xsh_amt_limit.sv
module xsh_amt_limit #(
   parameter int unsigned W     = 40,
   parameter int unsigned AMT_W = 7
) (
   input  logic [AMT_W-1:0] amt,
   output logic             dir_right,
   output logic [AMT_W:0]   mag
);
   localparam logic [AMT_W:0] LIMIT = (AMT_W+1)'(W);

   logic [AMT_W:0] ext;
   logic [AMT_W:0] raw;

   always_comb begin
      ext       = {amt[AMT_W-1], amt};
      dir_right = amt[AMT_W-1];
      raw       = dir_right ? (~ext + (AMT_W+1)'(1)) : ext;
      mag       = (raw > LIMIT) ? LIMIT : raw;
   end

endmodule

// File: rtl/xsh_shift_core.sv
module xsh_shift_core #(
   parameter int unsigned W     = 40,
   parameter int unsigned AMT_W = 7
) (
   input  logic [W-1:0]     operand,
   input  logic             carry_in,
   input  logic [AMT_W-1:0] amt,
   input  logic             arith,
   output logic [W-1:0]     shift_res,
   output logic [W-1:0]     rot_res,
   output logic             rot_carry
);
   localparam logic [AMT_W:0] RING_W = (AMT_W+1)'(W + 1);

   logic           go_right;
   logic [AMT_W:0] mag;

   xsh_amt_limit #(.W(W), .AMT_W(AMT_W)) u_lim (
      .amt       (amt),
      .dir_right (go_right),
      .mag       (mag)
   );

   logic [W-1:0] sh_left;
   logic [W-1:0] sh_right;
   logic [W:0]   ring;
   logic [W:0]   ring_l;
   logic [W:0]   ring_r;
   logic [W:0]   ring_o;

   always_comb begin
      sh_left = operand << mag;
      if (arith) begin
         sh_right = W'($signed(operand) >>> mag);
      end else begin
         sh_right = operand >> mag;
      end
      shift_res = go_right ? sh_right : sh_left;

      ring   = {carry_in, operand};
      ring_l = (ring << mag) | (ring >> (RING_W - mag));
      ring_r = (ring >> mag) | (ring << (RING_W - mag));
      ring_o = go_right ? ring_r : ring_l;
      rot_res   = ring_o[W-1:0];
      rot_carry = ring_o[W];
   end

endmodule

// File: rtl/xsh_sign_detect.sv
module xsh_sign_detect #(
   parameter int unsigned W     = 40,
   parameter int unsigned CNT_W = $clog2(W)
) (
   input  logic [W-1:0]     value,
   output logic [CNT_W-1:0] redundant
);
   logic [W-1:0] run;

   assign run[W-1] = 1'b1;

   generate
      for (genvar i = W - 2; i >= 0; i--) begin : g_run
         assign run[i] = run[i+1] & (value[i] == value[W-1]);
      end
   endgenerate

   always_comb begin
      redundant = '0;
      for (int k = 0; k < W - 1; k++) begin
         redundant = redundant + CNT_W'(run[k]);
      end
   end

endmodule

// File: rtl/xsh_field_unit.sv
module xsh_field_unit #(
   parameter int unsigned W     = 40,
   parameter int unsigned POS_W = 6
) (
   input  logic [W-1:0]     operand,
   input  logic [W-1:0]     src,
   input  logic [POS_W-1:0] pos,
   input  logic [POS_W-1:0] len,
   input  logic             sext,
   output logic [W-1:0]     ext_res,
   output logic [W-1:0]     dep_res
);
   localparam logic [POS_W-1:0] FULL = POS_W'(W);
   localparam logic [W-1:0]     ONES = '1;

   logic [W-1:0] len_mask;
   logic [W-1:0] field;
   logic [W-1:0] top_probe;
   logic         fill;
   logic [W-1:0] dep_mask;

   always_comb begin
      len_mask  = (len >= FULL) ? ONES : ~(ONES << len);
      field     = (operand >> pos) & len_mask;
      top_probe = field >> (len - POS_W'(1));
      fill      = sext && (len != '0) && (len < FULL) && top_probe[0];
      ext_res   = fill ? (field | ~len_mask) : field;

      dep_mask  = len_mask << pos;
      dep_res   = (operand & ~dep_mask) | ((src << pos) & dep_mask);
   end

endmodule

// File: rtl/xsh_unit.sv
module xsh_unit
   import xsh_pkg::*;
#(
   parameter int unsigned W     = XSH_DATA_W,
   parameter int unsigned AMT_W = XSH_AMT_W,
   parameter int unsigned POS_W = XSH_POS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             op_valid,
   input  logic [2:0]       op_code,
   input  logic [W-1:0]     operand,
   input  logic [W-1:0]     field_src,
   input  logic [AMT_W-1:0] shift_amt,
   input  logic [POS_W-1:0] fld_pos,
   input  logic [POS_W-1:0] fld_len,
   input  logic             fld_sext,
   output logic [W-1:0]     result,
   output logic             flag_zero,
   output logic             flag_neg,
   output logic             carry_q
);
   localparam int unsigned CNT_W = $clog2(W);

   generate
      if (W < 8) begin : g_bad_w
         $error("xsh_unit: W must be at least 8");
      end
      if ((AMT_W < 2) || ((2 ** (AMT_W - 1)) <= W)) begin : g_bad_amt
         $error("xsh_unit: AMT_W too small to hold +/-W");
      end
      if ((2 ** POS_W) <= W) begin : g_bad_pos
         $error("xsh_unit: POS_W too small to hold W");
      end
   endgenerate

   xsh_op_e op;
   assign op = xsh_op_e'(op_code);

   logic [W-1:0]     shift_res;
   logic [W-1:0]     rot_res;
   logic             rot_carry;
   logic [CNT_W-1:0] sd_cnt;
   logic [W-1:0]     ext_res;
   logic [W-1:0]     dep_res;

   xsh_shift_core #(.W(W), .AMT_W(AMT_W)) u_shift (
      .operand   (operand),
      .carry_in  (carry_q),
      .amt       (shift_amt),
      .arith     (op == OP_ASH),
      .shift_res (shift_res),
      .rot_res   (rot_res),
      .rot_carry (rot_carry)
   );

   xsh_sign_detect #(.W(W), .CNT_W(CNT_W)) u_sdet (
      .value     (operand),
      .redundant (sd_cnt)
   );

   xsh_field_unit #(.W(W), .POS_W(POS_W)) u_field (
      .operand (operand),
      .src     (field_src),
      .pos     (fld_pos),
      .len     (fld_len),
      .sext    (fld_sext),
      .ext_res (ext_res),
      .dep_res (dep_res)
   );

   always_comb begin
      unique case (op)
         OP_ASH, OP_LSH: result = shift_res;
         OP_ROT:         result = rot_res;
         OP_SGN:         result = W'(sd_cnt);
         OP_EXT:         result = ext_res;
         OP_DEP:         result = dep_res;
         default:        result = operand;
      endcase
   end

   assign flag_zero = (result == '0);
   assign flag_neg  = result[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carry_q <= 1'b0;
      end else if (op_valid && (op == OP_ROT)) begin
         carry_q <= rot_carry;
      end
   end

   localparam logic [AMT_W-1:0] AMT_WMAX = AMT_W'(W);

   AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && (op_code == 3'd2)) |=> $stable(carry_q)); // R5

   AST_ROT_ONE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && (op_code == 3'd2) && (shift_amt == AMT_W'(1)))
      |=> (carry_q == $past(operand[W-1]))); // R4

   AST_ROT_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_code == 3'd2) && (shift_amt == '0)) |-> (result == operand)); // R4

   AST_CLAMP_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_code == 3'd0) && !shift_amt[AMT_W-1] && (shift_amt >= AMT_WMAX))
      |-> (result == '0)); // R3

   AST_SGN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == 3'd3) |-> (result < W'(W))); // R6

   AST_EXT_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_code == 3'd4) && !fld_sext && (fld_len < POS_W'(W)))
      |-> ((result >> fld_len) == '0)); // R7

   AST_DEP_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_code == 3'd5) && (fld_pos != '0) && (fld_pos < POS_W'(W)))
      |-> (result[0] == operand[0])); // R9

   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code[2:1] == 2'b11) |-> (result == operand)); // R11

endmodule

// File: tb/xsh_unit_tb_top.sv
`timescale 1ns/1ps
module xsh_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = 3'd6;
   logic [39:0] operand = '0;
   logic [39:0] field_src = '0;
   logic [6:0]  shift_amt = '0;
   logic [5:0]  fld_pos = '0;
   logic [5:0]  fld_len = '0;
   logic        fld_sext = 1'b0;
   logic [39:0] result;
   logic        flag_zero;
   logic        flag_neg;
   logic        carry_q;

   int checks = 0;
   int failures = 0;
   logic exp_carry = 1'b0;

   always #10 clk = ~clk;

   xsh_unit dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .operand(operand), .field_src(field_src), .shift_amt(shift_amt),
      .fld_pos(fld_pos), .fld_len(fld_len), .fld_sext(fld_sext),
      .result(result), .flag_zero(flag_zero), .flag_neg(flag_neg),
      .carry_q(carry_q)
   );

   task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int amt_mag(input logic [6:0] a);
      int v;
      v = $signed(a);
      if (v < 0) v = -v;
      if (v > 40) v = 40;
      return v;
   endfunction

   function automatic logic [40:0] model(input logic [2:0] op, input logic [39:0] a,
                                         input logic [39:0] s, input logic [6:0] amt,
                                         input int pos, input int len, input logic sx,
                                         input logic cin);
      logic [39:0] r;
      logic [40:0] ring;
      logic        co;
      int          m;
      bit          right;
      m = amt_mag(amt);
      right = amt[6];
      r = a;
      co = cin;
      case (op)
         3'd0, 3'd1: begin
            for (int k = 0; k < m; k++) begin
               if (!right) r = {r[38:0], 1'b0};
               else if (op == 3'd0) r = {r[39], r[39:1]};
               else r = {1'b0, r[39:1]};
            end
         end
         3'd2: begin
            ring = {cin, a};
            for (int k = 0; k < m; k++) begin
               if (!right) ring = {ring[39:0], ring[40]};
               else ring = {ring[0], ring[40:1]};
            end
            r = ring[39:0];
            co = ring[40];
         end
         3'd3: begin
            int c;
            c = 0;
            for (int k = 38; k >= 0; k--) begin
               if (a[k] != a[39]) break;
               c++;
            end
            r = 40'(c);
         end
         3'd4: begin
            r = '0;
            for (int k = 0; k < 40; k++) begin
               if (k < len && (pos + k) < 40) r[k] = a[pos + k];
            end
            if (sx && len > 0 && len < 40) begin
               for (int k = len; k < 40; k++) r[k] = r[len - 1];
            end
         end
         3'd5: begin
            for (int k = 0; k < len; k++) begin
               if ((pos + k) < 40) r[pos + k] = s[k];
            end
         end
         default: r = a;
      endcase
      return {co, r};
   endfunction

   function automatic string tag_of(input logic [2:0] op, input logic [6:0] amt,
                                    input int pos, input int len);
      int v;
      v = $signed(amt);
      if ((op <= 3'd2) && (v > 40 || v < -40)) return "R3";
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R4";
         3'd3: return "R6";
         3'd4: return (len == 0 || len >= 40 || pos >= 40 || pos + len > 40) ? "R8" : "R7";
         3'd5: return "R9";
         default: return "R11";
      endcase
   endfunction

   task automatic run_op(input logic [2:0] op, input logic [39:0] a, input logic [39:0] s,
                         input logic [6:0] amt, input int pos, input int len,
                         input logic sx, input logic vld);
      logic [40:0] m;
      @(negedge clk);
      chk("R5", {39'd0, carry_q}, {39'd0, exp_carry});
      op_code = op; operand = a; field_src = s; shift_amt = amt;
      fld_pos = 6'(pos); fld_len = 6'(len); fld_sext = sx; op_valid = vld;
      #1;
      m = model(op, a, s, amt, pos, len, sx, exp_carry);
      chk(tag_of(op, amt, pos, len), result, m[39:0]);
      chk("R10", {38'd0, flag_zero, flag_neg}, {38'd0, (m[39:0] == '0), m[39]});
      @(posedge clk);
      if (vld && op == 3'd2) exp_carry = m[40];
   endtask

   function automatic logic [39:0] rnd40();
      logic [39:0] v;
      v = {$urandom(), $urandom()};
      case ($urandom_range(0, 4))
         0: v = {{8{v[31]}}, v[31:0]};
         1: v = {8'd0, v[31:0]};
         2: v = v >> $urandom_range(0, 39);
         3: v = ~(v >> $urandom_range(0, 39));
         default: ;
      endcase
      return v;
   endfunction

   initial begin
      int cyc;
      cyc = 0;
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      #35;
      chk("R5", {39'd0, carry_q}, 40'd0);
      chk("R10", {38'd0, flag_zero, flag_neg}, {38'd0, 1'b1, 1'b0});
      rst_n = 1'b1;

      // R1 / R2 / R3 amount edges
      run_op(3'd0, 40'h80_0000_0001, 0, 7'd1, 0, 0, 0, 1);
      run_op(3'd0, 40'h80_0000_0001, 0, -7'sd1, 0, 0, 0, 1);
      run_op(3'd1, 40'h80_0000_0001, 0, -7'sd1, 0, 0, 0, 1);
      run_op(3'd0, 40'h80_1234_5678, 0, -7'sd39, 0, 0, 0, 1);
      run_op(3'd0, 40'h80_1234_5678, 0, -7'sd40, 0, 0, 0, 1);
      run_op(3'd0, 40'h80_1234_5678, 0, -7'sd64, 0, 0, 0, 1);
      run_op(3'd1, 40'h80_1234_5678, 0, -7'sd50, 0, 0, 0, 1);
      run_op(3'd0, 40'h00_0000_0001, 0, 7'd39, 0, 0, 0, 1);
      run_op(3'd0, 40'hFF_FFFF_FFFF, 0, 7'd63, 0, 0, 0, 1);
      // R4 / R5 rotate chain and carry gating
      run_op(3'd2, 40'h80_0000_0000, 0, 7'd1, 0, 0, 0, 1);
      run_op(3'd2, 40'h00_0000_0000, 0, 7'd1, 0, 0, 0, 1);
      run_op(3'd2, 40'h00_0000_0001, 0, -7'sd1, 0, 0, 0, 0);
      run_op(3'd2, 40'h00_0000_0001, 0, -7'sd1, 0, 0, 0, 1);
      run_op(3'd2, 40'h12_3456_789A, 0, 7'd0, 0, 0, 0, 1);
      run_op(3'd2, 40'h12_3456_789A, 0, 7'd40, 0, 0, 0, 1);
      run_op(3'd2, 40'h12_3456_789A, 0, -7'sd60, 0, 0, 0, 1);
      run_op(3'd0, 40'hFF_0000_0000, 0, 7'd3, 0, 0, 0, 1);
      // R6
      run_op(3'd3, 40'h00_0000_0000, 0, 0, 0, 0, 0, 1);
      run_op(3'd3, 40'hFF_FFFF_FFFF, 0, 0, 0, 0, 0, 1);
      run_op(3'd3, 40'h40_0000_0000, 0, 0, 0, 0, 0, 1);
      run_op(3'd3, 40'hFF_FFFF_FFFE, 0, 0, 0, 0, 0, 1);
      run_op(3'd3, 40'h00_0000_0001, 0, 0, 0, 0, 0, 1);
      // R7 / R8
      run_op(3'd4, 40'h00_0000_F000, 0, 0, 12, 4, 1, 1);
      run_op(3'd4, 40'h00_0000_F000, 0, 0, 12, 4, 0, 1);
      run_op(3'd4, 40'h00_0000_7000, 0, 0, 12, 4, 1, 1);
      run_op(3'd4, 40'hAB_CDEF_0123, 0, 0, 5, 0, 1, 1);
      run_op(3'd4, 40'hAB_CDEF_0123, 0, 0, 0, 40, 1, 1);
      run_op(3'd4, 40'hAB_CDEF_0123, 0, 0, 4, 63, 0, 1);
      run_op(3'd4, 40'hAB_CDEF_0123, 0, 0, 36, 8, 1, 1);
      run_op(3'd4, 40'hAB_CDEF_0123, 0, 0, 40, 8, 1, 1);
      // R9
      run_op(3'd5, 40'hFF_FFFF_FFFF, 40'h0, 0, 8, 8, 0, 1);
      run_op(3'd5, 40'h00_0000_0000, 40'hFF_FFFF_FFFF, 0, 36, 8, 0, 1);
      run_op(3'd5, 40'h12_3456_789A, 40'hA5, 0, 0, 0, 0, 1);
      run_op(3'd5, 40'h12_3456_789A, 40'hCC_CCCC_CCCC, 0, 0, 40, 0, 1);
      run_op(3'd5, 40'h12_3456_789A, 40'hF, 0, 45, 4, 0, 1);
      // R11
      run_op(3'd6, 40'h9A_BCDE_F012, 0, 7'd5, 0, 0, 0, 1);
      run_op(3'd7, 40'h00_0000_0000, 0, 7'd5, 0, 0, 0, 1);

      for (int i = 0; i < 3000; i++) begin
         logic [6:0] amt;
         amt = ($urandom_range(0, 7) == 0) ? 7'($urandom()) : 7'($signed($urandom_range(0, 90)) - 45);
         run_op(3'($urandom()), rnd40(), rnd40(), amt,
                $urandom_range(0, 44), $urandom_range(0, 44),
                1'($urandom()), ($urandom_range(0, 3) != 0));
      end

      @(negedge clk);
      chk("R5", {39'd0, carry_q}, {39'd0, exp_carry});
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule